// File: doc/BRIEF.md
# Delayed-Transaction Bus Target

This block is the target side of a shared parallel bus with a hard latency limit. A master opens an access by raising a frame signal with a command, an address, byte enables and (for writes) data, and holds them until the target answers with either a ready pulse (the data phase is done) or a stop pulse (retry later). Memory writes are postable: the target takes them into a small queue and answers ready at once, and the queue drains to a slow local back end over a request/acknowledge handshake.

Reads and I/O writes are non-postable. The target latches such a request and starts it on the back end. If the result is there before the latency budget of 16 bus clocks runs out, the master gets it directly. Otherwise the target answers with a retry, leaves the bus free, and finishes the access in the background. When the master later repeats exactly the same request, it is answered on the next clock: with the prepared read data for a read, or with plain completion for a write. Only one such delayed request can be held at a time. Posted writes that were queued before it reach the back end first. Posted writes accepted after it stay in the queue until it is done. A finished result that nobody reclaims is dropped after 2^15 clocks.

The bus commands are encoded on two bits: 00 memory read, 01 memory write (the only postable one), 10 I/O read, 11 I/O write. Each access has one data phase. Every address is claimed.

Top module: `delayed_target`

## Requirements
- R1: A memory write (command 01) is answered with a ready pulse on the first clock edge after the frame is sampled, provided the posted queue has room. Each queued write later reaches the back end once, with its address, byte enables and data, in the order it was accepted.
- R2: A memory write that finds the posted queue full (4 entries by default) is answered with stop and is never sent to the back end.
- R3: A non-postable request (commands 00, 10, 11) that finds no delayed entry held is latched and started. If its back-end result becomes available by the 16th clock edge after the frame is first sampled, the answer is ready, and read data for reads. If completion and the deadline fall on the same edge, completion wins.
- R4: If that result is not available in time, the target answers stop exactly on the 16th edge and carries the access on to the back end by itself.
- R5: When a held entry is complete, a matching reissue (same command, address and byte enables, and the same data for a write) is answered with ready on the first edge. Reads return the prepared data. The entry is then released.
- R6: A matching reissue while the held entry is still running is answered with stop on the first edge.
- R7: A non-postable request that does not match the held entry is answered with stop on the first edge. It is not latched and never reaches the back end.
- R8: A delayed write is executed on the back end exactly once, however many times it is reissued.
- R9: Posted writes accepted before a delayed request reach the back end before it. Posted writes accepted while it is pending wait until it has completed.
- R10: A completed entry that is not reclaimed within 2^15 clocks is freed. A later identical request is then treated as new and goes to the back end again.
- R11: Ready and stop are never asserted together. Each lasts one clock, and device-select accompanies it.
- R12: While reset is asserted and just after it, ready, stop, device-select and the back-end request are all low.
- R13: A back-end request stays asserted with a stable address until it is acknowledged, and is dropped on the edge that samples the acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| busFrame | input | 1 | Master holds an access open |
| busCmd | input | 2 | Access command (00 mem read, 01 mem write, 10 I/O read, 11 I/O write) |
| busAddr | input | ADDR_W | Access address |
| busBe | input | DATA_W/8 | Byte enables |
| busWdata | input | DATA_W | Write data |
| busTrdy | output | 1 | Target-ready pulse: data phase done |
| busStop | output | 1 | Stop pulse: retry the access later |
| busDevsel | output | 1 | Device-select, asserted with either answer |
| busRdata | output | DATA_W | Read data, valid with the ready pulse of a read |
| beReq | output | 1 | Back-end request |
| beWe | output | 1 | Back-end write flag |
| beAddr | output | ADDR_W | Back-end address |
| beBe | output | DATA_W/8 | Back-end byte enables |
| beWdata | output | DATA_W | Back-end write data |
| beAck | input | 1 | Back-end acknowledge, one clock |
| beRdata | input | DATA_W | Back-end read data, valid with the acknowledge |

## Verification
The sharp corner is the clock on which the latency budget runs out while the back-end result is just becoming available. Both the ready path and the stop path are live on that edge. The bench drives a read against an idle back end whose acknowledge delay is tuned so that the completion lands exactly on the 16th edge, then a second read with one cycle more of delay. It expects ready with the fetched data on the first and stop on the second, each on edge 16, and the retried read then returns its data on its first reissue edge.

// File: rtl/dlyt_pkg.sv
package dlyt_pkg;

  // Bus command encoding; bit 0 marks a write
  localparam logic [1:0] CMD_MEM_RD = 2'b00;
  localparam logic [1:0] CMD_MEM_WR = 2'b01;
  localparam logic [1:0] CMD_IO_RD  = 2'b10;
  localparam logic [1:0] CMD_IO_WR  = 2'b11;

  typedef enum logic [1:0] {
    BUS_IDLE,
    BUS_WAIT,
    BUS_HOLD
  } busState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic latchReq;   // capture bus request into the delayed entry
    logic pushPost;   // enqueue a posted write
    logic issuePost;  // pop queue head into back-end registers
    logic issueDly;   // load delayed entry into back-end registers
    logic captureRd;  // store back-end read data
  } dpStrobe_t;

  function automatic logic cmdIsPostable(input logic [1:0] cmd);
    return cmd == CMD_MEM_WR;
  endfunction

endpackage

// File: rtl/dlyt_post_fifo.sv
module dlyt_post_fifo #(
  parameter int ITEM_W = 52,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              push,
  input  logic              pop,
  input  logic [ITEM_W-1:0] pushItem,
  output logic [ITEM_W-1:0] headItem,
  output logic              full,
  output logic              empty,
  output logic [CNT_W-1:0]  count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [ITEM_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  fill;

  function automatic logic [PTR_W-1:0] advance(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) store[wrPtr] <= pushItem;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fill  <= '0;
    end else begin
      if (push) wrPtr <= advance(wrPtr);
      if (pop)  rdPtr <= advance(rdPtr);
      case ({push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  assign headItem = store[rdPtr];
  assign full     = (fill == CNT_W'(DEPTH));
  assign empty    = (fill == '0);
  assign count    = fill;

endmodule

// File: rtl/dlyt_datapath.sv
module dlyt_datapath
  import dlyt_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int POST_DEPTH = 4,
  parameter int BE_W       = DATA_W / 8,
  parameter int CNT_W      = $clog2(POST_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [1:0]        busCmd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BE_W-1:0]   busBe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] beRdata,
  output logic              reqMatch,
  output logic              postFull,
  output logic              postEmpty,
  output logic [CNT_W-1:0]  postCount,
  output logic              beWe,
  output logic [ADDR_W-1:0] beAddr,
  output logic [BE_W-1:0]   beBe,
  output logic [DATA_W-1:0] beWdata,
  output logic [DATA_W-1:0] busRdata
);
  localparam int ITEM_W = ADDR_W + BE_W + DATA_W;

  // Delayed entry
  logic [1:0]        entCmd;
  logic [ADDR_W-1:0] entAddr;
  logic [BE_W-1:0]   entBe;
  logic [DATA_W-1:0] entData;
  logic [DATA_W-1:0] rdHold;

  logic [ITEM_W-1:0] headItem;
  logic [ADDR_W-1:0] headAddr;
  logic [BE_W-1:0]   headBe;
  logic [DATA_W-1:0] headData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entCmd  <= '0;
      entAddr <= '0;
      entBe   <= '0;
      entData <= '0;
    end else if (stb.latchReq) begin
      entCmd  <= busCmd;
      entAddr <= busAddr;
      entBe   <= busBe;
      entData <= busWdata;
    end
  end

  // A reissue must repeat every latched field; data counts for writes only
  always_comb begin
    reqMatch = (entCmd == busCmd) && (entAddr == busAddr) && (entBe == busBe);
    if (busCmd[0] && (entData != busWdata)) reqMatch = 1'b0;
  end

  dlyt_post_fifo #(
    .ITEM_W (ITEM_W),
    .DEPTH  (POST_DEPTH),
    .CNT_W  (CNT_W)
  ) postQ (
    .clk      (clk),
    .rstN     (rstN),
    .push     (stb.pushPost),
    .pop      (stb.issuePost),
    .pushItem ({busAddr, busBe, busWdata}),
    .headItem (headItem),
    .full     (postFull),
    .empty    (postEmpty),
    .count    (postCount)
  );

  assign {headAddr, headBe, headData} = headItem;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      beWe    <= 1'b0;
      beAddr  <= '0;
      beBe    <= '0;
      beWdata <= '0;
    end else if (stb.issuePost) begin
      beWe    <= 1'b1;
      beAddr  <= headAddr;
      beBe    <= headBe;
      beWdata <= headData;
    end else if (stb.issueDly) begin
      beWe    <= entCmd[0];
      beAddr  <= entAddr;
      beBe    <= entBe;
      beWdata <= entData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              rdHold <= '0;
    else if (stb.captureRd) rdHold <= beRdata;
  end

  assign busRdata = rdHold;

endmodule

// File: rtl/dlyt_control.sv
module dlyt_control
  import dlyt_pkg::*;
#(
  parameter int POST_DEPTH   = 4,
  parameter int LAT_INIT     = 16,
  parameter int DISCARD_CLKS = 32768,
  parameter int CNT_W        = $clog2(POST_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busFrame,
  input  logic [1:0]       busCmd,
  input  logic             reqMatch,
  input  logic             postFull,
  input  logic             postEmpty,
  input  logic [CNT_W-1:0] postCount,
  input  logic             beAck,
  output dpStrobe_t        stb,
  output logic             beReq,
  output logic             busTrdy,
  output logic             busStop,
  output logic             busDevsel
);
  localparam int LAT_W = $clog2(LAT_INIT + 1);
  localparam int DIS_W = (DISCARD_CLKS > 1) ? $clog2(DISCARD_CLKS) : 1;

  busState_e        state, nextState;
  logic             entValid, entIssued, entDone;
  logic [CNT_W-1:0] aheadCnt;
  logic [LAT_W-1:0] waitCnt;
  logic [DIS_W-1:0] discardCnt;
  logic             beIsDly;

  logic respTrdy, respStop, freeNow, discardNow, dlyReady, holdPosts, dlyFinish;

  assign discardNow = entValid && entDone && (discardCnt == DIS_W'(DISCARD_CLKS - 1));
  assign dlyReady   = entValid && !entIssued && (aheadCnt == '0);
  assign holdPosts  = entValid && !entDone && (aheadCnt == '0);
  assign dlyFinish  = beReq && beAck && beIsDly;

  // Bus answer and back-end issue decisions
  always_comb begin
    stb       = '0;
    respTrdy  = 1'b0;
    respStop  = 1'b0;
    freeNow   = 1'b0;
    nextState = state;

    case (state)
      BUS_IDLE: begin
        if (busFrame) begin
          nextState = BUS_HOLD;
          if (cmdIsPostable(busCmd)) begin
            if (!postFull) begin
              stb.pushPost = 1'b1;
              respTrdy     = 1'b1;
            end else begin
              respStop = 1'b1;
            end
          end else if (entValid) begin
            if (reqMatch && entDone) begin
              respTrdy = 1'b1;
              freeNow  = 1'b1;
            end else begin
              respStop = 1'b1;
            end
          end else begin
            stb.latchReq = 1'b1;
            nextState    = BUS_WAIT;
          end
        end
      end
      BUS_WAIT: begin
        if (entDone) begin
          respTrdy  = 1'b1;
          freeNow   = 1'b1;
          nextState = BUS_HOLD;
        end else if (waitCnt == LAT_W'(LAT_INIT - 1)) begin
          respStop  = 1'b1;
          nextState = BUS_HOLD;
        end
      end
      default: begin
        if (!busFrame) nextState = BUS_IDLE;
      end
    endcase

    if (!beReq) begin
      if (dlyReady)                     stb.issueDly  = 1'b1;
      else if (!postEmpty && !holdPosts) stb.issuePost = 1'b1;
    end
    stb.captureRd = dlyFinish;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= BUS_IDLE;
      busTrdy   <= 1'b0;
      busStop   <= 1'b0;
      busDevsel <= 1'b0;
      waitCnt   <= '0;
    end else begin
      state     <= nextState;
      busTrdy   <= respTrdy;
      busStop   <= respStop;
      busDevsel <= respTrdy | respStop;
      if (stb.latchReq)        waitCnt <= LAT_W'(1);
      else if (state == BUS_WAIT) waitCnt <= waitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      beReq   <= 1'b0;
      beIsDly <= 1'b0;
    end else if (stb.issueDly || stb.issuePost) begin
      beReq   <= 1'b1;
      beIsDly <= stb.issueDly;
    end else if (beAck) begin
      beReq   <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entValid   <= 1'b0;
      entIssued  <= 1'b0;
      entDone    <= 1'b0;
      aheadCnt   <= '0;
      discardCnt <= '0;
    end else if (stb.latchReq) begin
      entValid   <= 1'b1;
      entIssued  <= 1'b0;
      entDone    <= 1'b0;
      aheadCnt   <= postCount - CNT_W'(stb.issuePost);
      discardCnt <= '0;
    end else if (freeNow || discardNow) begin
      entValid  <= 1'b0;
      entIssued <= 1'b0;
      entDone   <= 1'b0;
    end else begin
      if (stb.issueDly) entIssued <= 1'b1;
      if (dlyFinish)    entDone   <= 1'b1;
      if (stb.issuePost && (aheadCnt != '0)) aheadCnt <= aheadCnt - 1'b1;
      if (entValid && entDone) discardCnt <= discardCnt + 1'b1;
    end
  end

endmodule

// File: rtl/delayed_target.sv
module delayed_target
  import dlyt_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 32,
  parameter int POST_DEPTH   = 4,
  parameter int LAT_INIT     = 16,
  parameter int DISCARD_CLKS = 32768
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busFrame,
  input  logic [1:0]          busCmd,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W/8-1:0] busBe,
  input  logic [DATA_W-1:0]   busWdata,
  output logic                busTrdy,
  output logic                busStop,
  output logic                busDevsel,
  output logic [DATA_W-1:0]   busRdata,
  output logic                beReq,
  output logic                beWe,
  output logic [ADDR_W-1:0]   beAddr,
  output logic [DATA_W/8-1:0] beBe,
  output logic [DATA_W-1:0]   beWdata,
  input  logic                beAck,
  input  logic [DATA_W-1:0]   beRdata
);
  localparam int BE_W  = DATA_W / 8;
  localparam int CNT_W = $clog2(POST_DEPTH + 1);

  dpStrobe_t        stb;
  logic             reqMatch, postFull, postEmpty;
  logic [CNT_W-1:0] postCount;

  dlyt_control #(
    .POST_DEPTH   (POST_DEPTH),
    .LAT_INIT     (LAT_INIT),
    .DISCARD_CLKS (DISCARD_CLKS),
    .CNT_W        (CNT_W)
  ) ctl (
    .clk       (clk),
    .rstN      (rstN),
    .busFrame  (busFrame),
    .busCmd    (busCmd),
    .reqMatch  (reqMatch),
    .postFull  (postFull),
    .postEmpty (postEmpty),
    .postCount (postCount),
    .beAck     (beAck),
    .stb       (stb),
    .beReq     (beReq),
    .busTrdy   (busTrdy),
    .busStop   (busStop),
    .busDevsel (busDevsel)
  );

  dlyt_datapath #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .POST_DEPTH (POST_DEPTH),
    .BE_W       (BE_W),
    .CNT_W      (CNT_W)
  ) dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .busCmd    (busCmd),
    .busAddr   (busAddr),
    .busBe     (busBe),
    .busWdata  (busWdata),
    .beRdata   (beRdata),
    .reqMatch  (reqMatch),
    .postFull  (postFull),
    .postEmpty (postEmpty),
    .postCount (postCount),
    .beWe      (beWe),
    .beAddr    (beAddr),
    .beBe      (beBe),
    .beWdata   (beWdata),
    .busRdata  (busRdata)
  );

endmodule

// File: rtl/delayed_target_chk.sv
module delayed_target_chk #(
  parameter int ADDR_W   = 16,
  parameter int LAT_INIT = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              busFrame,
  input logic              busTrdy,
  input logic              busStop,
  input logic              beReq,
  input logic              beAck,
  input logic [ADDR_W-1:0] beAddr
);
  localparam int AGE_W = $clog2(LAT_INIT + 2);

  logic [AGE_W-1:0] frameAge;
  logic             answered;

  always_ff @(posedge clk) begin
    if (!rstN || !busFrame) begin
      frameAge <= '0;
      answered <= 1'b0;
    end else begin
      if (busTrdy || busStop) answered <= 1'b1;
      else if (frameAge != '1) frameAge <= frameAge + 1'b1;
    end
  end

  // R11
  resp_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busTrdy && busStop));

  // R11
  resp_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busTrdy || busStop) |=> !(busTrdy || busStop));

  // R4
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busFrame && !answered && !(busTrdy || busStop)) |-> (frameAge < AGE_W'(LAT_INIT)));

  // R13
  be_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (beReq && !beAck) |=> (beReq && $stable(beAddr)));

  // R13
  be_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (beReq && beAck) |=> !beReq);

endmodule

bind delayed_target delayed_target_chk #(
  .ADDR_W   (ADDR_W),
  .LAT_INIT (LAT_INIT)
) chkInst (
  .clk      (clk),
  .rstN     (rstN),
  .busFrame (busFrame),
  .busTrdy  (busTrdy),
  .busStop  (busStop),
  .beReq    (beReq),
  .beAck    (beAck),
  .beAddr   (beAddr)
);

// File: tb/delayed_target_test.sv
`timescale 1ns/1ps
module delayed_target_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busFrame = 1'b0;
  logic [1:0]  busCmd = 2'b00;
  logic [15:0] busAddr = '0;
  logic [3:0]  busBe = '0;
  logic [31:0] busWdata = '0;
  logic        busTrdy, busStop, busDevsel;
  logic [31:0] busRdata;
  logic        beReq, beWe;
  logic [15:0] beAddr;
  logic [3:0]  beBe;
  logic [31:0] beWdata;
  logic        beAck = 1'b0;
  logic [31:0] beRdata;

  int checks = 0;
  int fails  = 0;
  int beLat  = 2;
  int beCnt  = 0;
  bit finished = 0;

  typedef struct {
    logic        we;
    logic [15:0] addr;
    logic [3:0]  be;
    logic [31:0] data;
    string       tag;
  } beOp_t;
  beOp_t expQ[$];

  always #5 clk = ~clk;

  delayed_target uut (
    .clk(clk), .rstN(rstN), .busFrame(busFrame), .busCmd(busCmd),
    .busAddr(busAddr), .busBe(busBe), .busWdata(busWdata),
    .busTrdy(busTrdy), .busStop(busStop), .busDevsel(busDevsel),
    .busRdata(busRdata), .beReq(beReq), .beWe(beWe), .beAddr(beAddr),
    .beBe(beBe), .beWdata(beWdata), .beAck(beAck), .beRdata(beRdata)
  );

  function automatic logic [31:0] rdValue(input logic [15:0] a);
    return {a, ~a};
  endfunction

  assign beRdata = rdValue(beAddr);

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic expectOp(input logic we, input logic [15:0] a, input logic [3:0] be,
                          input logic [31:0] d, input string tag);
    beOp_t op;
    op.we = we; op.addr = a; op.be = be; op.data = d; op.tag = tag;
    expQ.push_back(op);
  endtask

  // Back-end model and scoreboard monitor
  always @(negedge clk) begin
    if (beAck) begin
      beAck = 1'b0;
    end else if (rstN && beReq) begin
      if (beCnt >= beLat) begin
        beAck = 1'b1;
        beCnt = 0;
        if (expQ.size() == 0) begin
          chk(1'b0, "R7 unexpected back-end access addr", 32'(beAddr), 32'hFFFF_FFFF);
        end else begin
          beOp_t op;
          op = expQ.pop_front();
          chk(beWe == op.we, {op.tag, " back-end write flag"}, 32'(beWe), 32'(op.we));
          chk(beAddr == op.addr, {op.tag, " back-end address/order"}, 32'(beAddr), 32'(op.addr));
          chk(beBe == op.be, {op.tag, " back-end byte enables"}, 32'(beBe), 32'(op.be));
          if (op.we) chk(beWdata == op.data, {op.tag, " back-end write data"}, beWdata, op.data);
        end
      end else begin
        beCnt++;
      end
    end
  end

  task automatic access(input logic [1:0] cmd, input logic [15:0] a, input logic [3:0] be,
                        input logic [31:0] d, output logic gotTrdy, output logic gotStop,
                        output int waited, output logic [31:0] rd);
    @(negedge clk);
    busFrame = 1'b1; busCmd = cmd; busAddr = a; busBe = be; busWdata = d;
    waited = 0;
    do begin
      @(negedge clk);
      waited++;
    end while (!(busTrdy || busStop) && waited < 100);
    gotTrdy = busTrdy;
    gotStop = busStop;
    rd = busRdata;
    chk(!(busTrdy && busStop) && busDevsel, "R11 single answer with device-select",
        {busTrdy, busStop, busDevsel}, 32'b101);
    busFrame = 1'b0;
    @(negedge clk);
    chk(!busTrdy && !busStop, "R11 answer lasts one clock", {busTrdy, busStop}, 32'b0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic t, s;
    int w;
    logic [31:0] rd;

    repeat (3) @(negedge clk);
    chk(!busTrdy && !busStop && !busDevsel && !beReq, "R12 outputs low in reset",
        {busTrdy, busStop, busDevsel, beReq}, 32'b0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busTrdy && !busStop && !busDevsel && !beReq, "R12 outputs low after reset",
        {busTrdy, busStop, busDevsel, beReq}, 32'b0);

    // R1 posted writes
    beLat = 2;
    expectOp(1'b1, 16'h0100, 4'hF, 32'h1111_1111, "R1");
    access(2'b01, 16'h0100, 4'hF, 32'h1111_1111, t, s, w, rd);
    chk(t && w == 1, "R1 posted write ready on first edge", w, 1);
    expectOp(1'b1, 16'h0104, 4'h3, 32'h2222_2222, "R1");
    access(2'b01, 16'h0104, 4'h3, 32'h2222_2222, t, s, w, rd);
    chk(t && w == 1, "R1 second posted write ready", w, 1);
    idle(20);

    // R3 fast completion
    beLat = 3;
    expectOp(1'b0, 16'h0200, 4'hF, 32'h0, "R3");
    access(2'b00, 16'h0200, 4'hF, 32'h0, t, s, w, rd);
    chk(t && w <= 16, "R3 quick read answered ready", w, 16);
    chk(rd == rdValue(16'h0200), "R3 quick read data", rd, rdValue(16'h0200));
    idle(5);

    // R3 tie: completion on the deadline edge wins
    beLat = 12;
    expectOp(1'b0, 16'h0204, 4'hF, 32'h0, "R3");
    access(2'b00, 16'h0204, 4'hF, 32'h0, t, s, w, rd);
    chk(t && !s && w == 16, "R3 completion on deadline edge gives ready", {t, s, 8'(w)}, {2'b10, 8'd16});
    chk(rd == rdValue(16'h0204), "R3 deadline read data", rd, rdValue(16'h0204));
    idle(5);

    // R4 one cycle late: stop on edge 16, then R5 reclaim
    beLat = 13;
    expectOp(1'b0, 16'h0208, 4'hF, 32'h0, "R4");
    access(2'b00, 16'h0208, 4'hF, 32'h0, t, s, w, rd);
    chk(s && !t && w == 16, "R4 stop on edge 16", {t, s, 8'(w)}, {2'b01, 8'd16});
    idle(40);
    access(2'b00, 16'h0208, 4'hF, 32'h0, t, s, w, rd);
    chk(t && w == 1, "R5 reissue answered ready at once", w, 1);
    chk(rd == rdValue(16'h0208), "R5 reissue read data", rd, rdValue(16'h0208));
    idle(5);

    // R6, R7 while an I/O read is pending; posted write held (R9)
    beLat = 30;
    expectOp(1'b0, 16'h0300, 4'h1, 32'h0, "R9");
    access(2'b10, 16'h0300, 4'h1, 32'h0, t, s, w, rd);
    chk(s && w == 16, "R4 slow I/O read stopped", w, 16);
    access(2'b10, 16'h0300, 4'h1, 32'h0, t, s, w, rd);
    chk(s && w == 1, "R6 matching reissue while running gets stop", {t, s, 8'(w)}, {2'b01, 8'd1});
    access(2'b10, 16'h0304, 4'h1, 32'h0, t, s, w, rd);
    chk(s && w == 1, "R7 different request gets stop", {t, s, 8'(w)}, {2'b01, 8'd1});
    access(2'b10, 16'h0300, 4'h2, 32'h0, t, s, w, rd);
    chk(s && w == 1, "R7 different byte enables gets stop", {t, s, 8'(w)}, {2'b01, 8'd1});
    expectOp(1'b1, 16'h0380, 4'hF, 32'h3333_3333, "R9");
    access(2'b01, 16'h0380, 4'hF, 32'h3333_3333, t, s, w, rd);
    chk(t && w == 1, "R1 write posted while delayed pending", w, 1);
    idle(60);
    access(2'b10, 16'h0300, 4'h1, 32'h0, t, s, w, rd);
    chk(t && w == 1, "R5 I/O read reclaimed", w, 1);
    chk(rd == rdValue(16'h0300), "R5 I/O read data", rd, rdValue(16'h0300));
    idle(40);

    // R8 delayed write
    beLat = 30;
    expectOp(1'b1, 16'h0400, 4'hF, 32'hDEAD_BEEF, "R8");
    access(2'b11, 16'h0400, 4'hF, 32'hDEAD_BEEF, t, s, w, rd);
    chk(s && w == 16, "R4 slow I/O write stopped", w, 16);
    idle(60);
    access(2'b11, 16'h0400, 4'hF, 32'hDEAD_BEE0, t, s, w, rd);
    chk(s && w == 1, "R7 write with other data gets stop", {t, s, 8'(w)}, {2'b01, 8'd1});
    access(2'b11, 16'h0400, 4'hF, 32'hDEAD_BEEF, t, s, w, rd);
    chk(t && w == 1, "R8 write reissue gets completion", {t, s, 8'(w)}, {2'b10, 8'd1});
    idle(10);

    // R9 ordering: posts ahead drain first, later post waits
    beLat = 20;
    expectOp(1'b1, 16'h0500, 4'hF, 32'h5000_0001, "R9");
    access(2'b01, 16'h0500, 4'hF, 32'h5000_0001, t, s, w, rd);
    expectOp(1'b1, 16'h0504, 4'hF, 32'h5000_0002, "R9");
    access(2'b01, 16'h0504, 4'hF, 32'h5000_0002, t, s, w, rd);
    expectOp(1'b0, 16'h0508, 4'hF, 32'h0, "R9");
    access(2'b00, 16'h0508, 4'hF, 32'h0, t, s, w, rd);
    chk(s && w == 16, "R9 read behind posted writes stopped", w, 16);
    expectOp(1'b1, 16'h050C, 4'hF, 32'h5000_0003, "R9");
    access(2'b01, 16'h050C, 4'hF, 32'h5000_0003, t, s, w, rd);
    chk(t, "R9 later write posted", t, 1);
    idle(150);
    access(2'b00, 16'h0508, 4'hF, 32'h0, t, s, w, rd);
    chk(t && rd == rdValue(16'h0508), "R9 ordered read data", rd, rdValue(16'h0508));
    idle(40);

    // R2 full queue
    beLat = 40;
    for (int i = 0; i < 5; i++) begin
      expectOp(1'b1, 16'h0700 + 16'(i * 4), 4'hF, 32'h7000_0000 + 32'(i), "R2");
      access(2'b01, 16'h0700 + 16'(i * 4), 4'hF, 32'h7000_0000 + 32'(i), t, s, w, rd);
      chk(t, "R1 write accepted while room", t, 1);
    end
    access(2'b01, 16'h07F0, 4'hF, 32'h7FFF_FFFF, t, s, w, rd);
    chk(s && !t && w == 1, "R2 full queue gives stop", {t, s, 8'(w)}, {2'b01, 8'd1});
    idle(260);

    // R10 discard of an unclaimed result
    beLat = 30;
    expectOp(1'b0, 16'h0600, 4'hF, 32'h0, "R10");
    access(2'b00, 16'h0600, 4'hF, 32'h0, t, s, w, rd);
    chk(s && w == 16, "R10 read stopped", w, 16);
    idle(33000);
    beLat = 2;
    expectOp(1'b0, 16'h0600, 4'hF, 32'h0, "R10");
    access(2'b00, 16'h0600, 4'hF, 32'h0, t, s, w, rd);
    chk(t && w > 1 && w <= 16, "R10 discarded entry refetched", w, 16);
    chk(rd == rdValue(16'h0600), "R10 refetched data", rd, rdValue(16'h0600));
    idle(20);

    chk(expQ.size() == 0, "R9 all expected back-end accesses seen", expQ.size(), 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog R12 run did not complete actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule